// File: doc/BRIEF.md
# Filter Acquisition Trigger Controller

This block decides when a digital filter output path is allowed to hand samples to its receive FIFO. A configuration set (enable, acquisition mode, trigger source, edge polarity, discard count, threshold select and DMA enable) chooses among three ways of running. Free-running modes start as soon as the path is enabled. Triggered modes wait for an edge on a selected trigger line. Window mode passes samples only while the selected trigger line is high. Each mode exists in a continuous form, and the free-running and triggered modes also have a one-sample single-shot form.

On every restart the path drops a programmable number of incoming samples before any sample is written. A small show-ahead FIFO holds the accepted samples. It raises a threshold event either as soon as it holds data or once it is at least half full. The event can be forwarded as a DMA request. Two status flags report whether the path is acquiring and whether it is busy at all, which includes waiting for a trigger.

Top module: `acq_trig_ctrl`

## Requirements
- R1: `cfg_mode` encodings: 0 free-running continuous, 1 free-running single-shot, 2 triggered continuous, 3 triggered single-shot, 4 window continuous. The codes 5, 6 and 7 behave exactly like code 0.
- R2: In modes 0, 1 and 4, the first rising clock edge that sees `cfg_en` high after idle sets `run_flag` and `active_flag` together.
- R3: When `cfg_en` is low at a clock edge, no sample is written at that edge, and `run_flag` and `active_flag` are 0 after it. Both flags are 0 after reset.
- R4: In modes 2 and 3, enabling sets `active_flag` with `run_flag` at 0. `run_flag` stays 0 until a selected trigger edge is seen.
- R5: `cfg_src` = 0 selects `trig_tmr`, which always triggers on its falling edge whatever `cfg_falling` says. `cfg_src` = 2 selects `trig_ext`, which triggers on its rising edge when `cfg_falling` = 0 and on its falling edge when `cfg_falling` = 1. The codes 1 and 3 never trigger and give a trigger level of 0.
- R6: Each trigger input passes through two flip-flops before its edge is detected. `run_flag` therefore rises at the third rising clock edge after a trigger line changes between edges.
- R7: After each start (enable from idle, or a trigger edge in a triggered mode), the first `cfg_discard` valid samples are dropped. A count of 0 drops none.
- R8: A single-shot mode writes exactly one sample after the discard count is used up, and `run_flag` is 0 at the following edge. Mode 3 then waits for a new trigger with `active_flag` at 1. Mode 1 goes to `active_flag` 0 and restarts only after `cfg_en` has been low for at least one clock edge and is set again.
- R9: A trigger edge that arrives while `run_flag` is 1 has no effect: it neither restarts the discard count nor ends a capture.
- R10: In mode 4, a valid sample is written or counted toward the discard only when the synchronized level of the selected trigger is 1.
- R11: With `cfg_half_thr` = 0, `thr_evt` is 1 whenever `fifo_level` is nonzero. With `cfg_half_thr` = 1, `thr_evt` is 1 whenever `fifo_level` is at least DEPTH/2. `dma_req` equals `thr_evt` when `cfg_dma_en` = 1 and is 0 otherwise.
- R12: The FIFO is show-ahead. `rd_data` shows the oldest entry, and a pulse on `rd_en` removes it. A read of an empty FIFO is ignored. A sample offered while the FIFO is full is dropped and does not count as the single-shot capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Path enable |
| cfg_mode | input | 3 | Acquisition mode |
| cfg_src | input | 2 | Trigger source select |
| cfg_falling | input | 1 | Edge polarity for the external trigger |
| cfg_discard | input | DISC_W | Samples to drop after each start |
| cfg_half_thr | input | 1 | Threshold select: nonempty or half full |
| cfg_dma_en | input | 1 | Forward the threshold event as a DMA request |
| trig_tmr | input | 1 | Internal timer trigger line |
| trig_ext | input | 1 | External trigger line |
| smp_valid | input | 1 | Incoming sample strobe |
| smp_data | input | DATA_W | Incoming sample value |
| rd_en | input | 1 | FIFO read (pop) |
| rd_data | output | DATA_W | Oldest FIFO entry |
| fifo_level | output | $clog2(DEPTH+1) | FIFO occupancy |
| thr_evt | output | 1 | FIFO threshold event |
| dma_req | output | 1 | DMA request |
| run_flag | output | 1 | Path acquiring |
| active_flag | output | 1 | Path running or waiting for a trigger |

## Verification
The hardest case to reach from the ports is a trigger edge that lands while a triggered single-shot capture is still working off its discard count. The edge must arrive after the run flag has risen but before the last discarded sample. The stimulus gets there by setting a large discard count and holding the sample strobe low during the trigger pulse, so the capture stays in its running phase for many cycles. It then toggles the trigger line again and streams samples. A reference model tracks the synchronizer delay, the discard counter and the queue contents cycle by cycle, and it shows whether that second edge reloaded the discard count or ended the capture early.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } acq_state_e;

  typedef struct packed {
    logic trig;
    logic single;
    logic window;
  } mode_kind_t;

  // Codes above 4 fall back to free-running continuous.
  function automatic mode_kind_t decode_mode(input logic [2:0] m);
    mode_kind_t k;
    k = '0;
    case (m)
      3'd1: k.single = 1'b1;
      3'd2: k.trig = 1'b1;
      3'd3: begin k.trig = 1'b1; k.single = 1'b1; end
      3'd4: k.window = 1'b1;
      default: k = '0;
    endcase
    return k;
  endfunction

  function automatic logic thr_hit(input int unsigned level, input logic half,
                                   input int unsigned depth);
    if (half) return level >= depth / 2;
    return level != 0;
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic lvl,
  output logic hit
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl = s2;
  assign hit = fall_sel ? (s3 & ~s2) : (~s3 & s2);
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_trig_pkg::*;
#(
  parameter int DISC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [2:0]        mode,
  input  logic [DISC_W-1:0] discard,
  input  logic              trig_edge,
  input  logic              trig_lvl,
  input  logic              smp_valid,
  input  logic              fifo_full,
  output logic              wr,
  output logic              run,
  output logic              active
);
  acq_state_e        st;
  logic [DISC_W-1:0] disc_left;
  mode_kind_t        kind;
  logic              gate_ok;
  logic              disc_step;

  assign kind      = decode_mode(mode);
  assign gate_ok   = kind.window ? trig_lvl : 1'b1;
  assign disc_step = en && (st == ST_RUN) && smp_valid && gate_ok && (disc_left != '0);
  assign wr        = en && (st == ST_RUN) && smp_valid && gate_ok && (disc_left == '0)
                     && !fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      disc_left <= '0;
    end else if (!en) begin
      st        <= ST_IDLE;
      disc_left <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (kind.trig) begin
            st <= ST_WAIT;
          end else begin
            st        <= ST_RUN;
            disc_left <= discard;
          end
        end
        ST_WAIT: begin
          if (trig_edge) begin
            st        <= ST_RUN;
            disc_left <= discard;
          end
        end
        ST_RUN: begin
          if (disc_step) disc_left <= disc_left - 1'b1;
          if (wr && kind.single) st <= kind.trig ? ST_WAIT : ST_DONE;
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  assign run    = (st == ST_RUN);
  assign active = (st == ST_RUN) || (st == ST_WAIT);

  a_r3_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!run && !active));

  a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !run && en && !trig_edge) |=> !run);

  a_r8_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && kind.single) |=> !run);

  a_r9_run_edge_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && trig_edge && !disc_step && !wr && (disc_left != '0)) |=> $stable(disc_left));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import acq_trig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic              half_sel,
  output logic [DATA_W-1:0] rdata,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              thr
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic              pop;

  assign full = (level == LVL_W'(DEPTH));
  assign pop  = rd && (level != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (wr) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({wr, pop})
        2'b10: level <= level + 1'b1;
        2'b01: level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
  assign thr   = thr_hit(int'(level), half_sel, DEPTH);

  a_r12_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && !wr) |=> (level == '0));
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_trig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int DISC_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int NTRIG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [2:0]        cfg_mode,
  input  logic [1:0]        cfg_src,
  input  logic              cfg_falling,
  input  logic [DISC_W-1:0] cfg_discard,
  input  logic              cfg_half_thr,
  input  logic              cfg_dma_en,
  input  logic              trig_tmr,
  input  logic              trig_ext,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              thr_evt,
  output logic              dma_req,
  output logic              run_flag,
  output logic              active_flag
);
  logic [NTRIG-1:0] tin, fsel, tlvl, thit;
  logic             sel_lvl, sel_edge;
  logic             fifo_wr, fifo_full;

  // index 0: timer line, forced falling; index 1: external line, polarity selectable
  assign tin  = {trig_ext, trig_tmr};
  assign fsel = {cfg_falling, 1'b1};

  for (genvar i = 0; i < NTRIG; i++) begin : g_trig
    trig_sync u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (tin[i]),
      .fall_sel (fsel[i]),
      .lvl      (tlvl[i]),
      .hit      (thit[i])
    );
  end

  always_comb begin
    case (cfg_src)
      2'd0: begin sel_lvl = tlvl[0]; sel_edge = thit[0]; end
      2'd2: begin sel_lvl = tlvl[1]; sel_edge = thit[1]; end
      default: begin sel_lvl = 1'b0; sel_edge = 1'b0; end
    endcase
  end

  acq_sequencer #(.DISC_W(DISC_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .mode      (cfg_mode),
    .discard   (cfg_discard),
    .trig_edge (sel_edge),
    .trig_lvl  (sel_lvl),
    .smp_valid (smp_valid),
    .fifo_full (fifo_full),
    .wr        (fifo_wr),
    .run       (run_flag),
    .active    (active_flag)
  );

  rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (fifo_wr),
    .wdata    (smp_data),
    .rd       (rd_en),
    .half_sel (cfg_half_thr),
    .rdata    (rd_data),
    .level    (fifo_level),
    .full     (fifo_full),
    .thr      (thr_evt)
  );

  assign dma_req = thr_evt & cfg_dma_en;

  a_r3_write_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (run_flag && cfg_en));

  a_r11_dma_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dma_en || fifo_level == '0) |-> !dma_req);
endmodule

// File: tb/sim_acq_trig_ctrl.sv
module sim_acq_trig_ctrl;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int DISC_W = 8;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 0, cfg_falling = 0, cfg_half_thr = 0, cfg_dma_en = 0;
  logic [2:0] cfg_mode = 0;
  logic [1:0] cfg_src = 0;
  logic [DISC_W-1:0] cfg_discard = 0;
  logic trig_tmr = 0, trig_ext = 0, smp_valid = 0, rd_en = 0;
  logic [DATA_W-1:0] smp_data = 0;
  logic [DATA_W-1:0] rd_data;
  logic [LVL_W-1:0] fifo_level;
  logic thr_evt, dma_req, run_flag, active_flag;

  always #10 clk = ~clk;

  acq_trig_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DISC_W(DISC_W)) u0 (.*);

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R3";

  // reference model state: 0 idle, 1 wait, 2 run, 3 done
  int m_st = 0, m_disc = 0;
  bit t1 = 0, t2 = 0, t3 = 0, e1 = 0, e2 = 0, e3 = 0;
  logic [DATA_W-1:0] q [$];

  always @(posedge clk) begin
    bit lvl, edg, trg, sgl, win, gate, acc, dstep;
    int md;
    if (!rst_n) begin
      m_st = 0; m_disc = 0; q.delete();
      t1 = 0; t2 = 0; t3 = 0; e1 = 0; e2 = 0; e3 = 0;
    end else begin
      md  = (cfg_mode > 4) ? 0 : int'(cfg_mode);
      trg = (md == 2 || md == 3);
      sgl = (md == 1 || md == 3);
      win = (md == 4);
      lvl = 0; edg = 0;
      if (cfg_src == 0) begin lvl = t2; edg = t3 && !t2; end
      if (cfg_src == 2) begin lvl = e2; edg = cfg_falling ? (e3 && !e2) : (!e3 && e2); end
      gate  = win ? lvl : 1'b1;
      dstep = cfg_en && m_st == 2 && smp_valid && gate && m_disc > 0;
      acc   = cfg_en && m_st == 2 && smp_valid && gate && m_disc == 0 && q.size() < DEPTH;
      if (rd_en && q.size() > 0) void'(q.pop_front());
      if (acc) q.push_back(smp_data);
      if (!cfg_en) begin m_st = 0; m_disc = 0; end
      else if (m_st == 0) begin
        if (trg) m_st = 1; else begin m_st = 2; m_disc = int'(cfg_discard); end
      end else if (m_st == 1) begin
        if (edg) begin m_st = 2; m_disc = int'(cfg_discard); end
      end else if (m_st == 2) begin
        if (dstep) m_disc--;
        if (acc && sgl) m_st = trg ? 1 : 3;
      end
      t3 = t2; t2 = t1; t1 = trig_tmr;
      e3 = e2; e2 = e1; e1 = trig_ext;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    bit ethr;
    if (rst_n) begin
      ethr = cfg_half_thr ? (q.size() >= DEPTH / 2) : (q.size() != 0);
      chk("run_flag", int'(run_flag), int'(m_st == 2));
      chk("active_flag", int'(active_flag), int'(m_st == 1 || m_st == 2));
      chk("fifo_level", int'(fifo_level), q.size());
      chk("thr_evt", int'(thr_evt), int'(ethr));
      chk("dma_req", int'(dma_req), int'(ethr && cfg_dma_en));
      if (q.size() > 0) chk("rd_data", int'(rd_data), int'(q[0]));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic samples(int n, bit rd = 0);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1; smp_data = smp_data + 16'd1; rd_en = rd;
      step();
    end
    smp_valid = 0; rd_en = 0;
  endtask

  task automatic drain();
    cfg_en = 0; rd_en = 1; step(DEPTH + 2); rd_en = 0; step();
  endtask

  task automatic pulse_line(bit ext, bit val, int hold);
    if (ext) trig_ext = val; else trig_tmr = val;
    step(hold);
  endtask

  initial begin
    step(3);
    cur_req = "R3";
    checks++; if (run_flag !== 0 || active_flag !== 0 || fifo_level !== 0) begin
      errors++; $display("FAIL R3 reset flags actual %0d%0d expected 00", run_flag, active_flag);
    end
    rst_n = 1; step(2);

    cur_req = "R2"; cfg_mode = 0; cfg_discard = 0; cfg_en = 1; step();
    checks++; if (run_flag !== 1) begin
      errors++; $display("FAIL R2 run after enable actual %0d expected 1", run_flag);
    end
    samples(5); rd_en = 1; step(2); rd_en = 0; drain();

    cur_req = "R1"; cfg_mode = 6; cfg_en = 1; step(); samples(3); drain();
    cfg_mode = 5; cfg_en = 1; step(); samples(2); drain();

    cur_req = "R7"; cfg_mode = 0; cfg_discard = 3; cfg_en = 1; step(); samples(6);
    cfg_en = 0; step(); cfg_en = 1; step(); samples(5); drain();

    cur_req = "R11"; cfg_discard = 0; cfg_half_thr = 1; cfg_dma_en = 1; cfg_en = 1; step();
    for (int i = 0; i < 6; i++) samples(1);
    rd_en = 1; step(3); rd_en = 0; cfg_dma_en = 0; step(2); drain();
    cfg_half_thr = 0; cfg_dma_en = 1; cfg_en = 1; step(); samples(1); step(2);
    cfg_dma_en = 0; step(); drain();

    cur_req = "R12"; cfg_en = 1; step(); samples(DEPTH + 3);
    samples(3, 1); rd_en = 1; step(DEPTH + 3); rd_en = 0; drain();

    cur_req = "R4"; cfg_mode = 2; cfg_src = 2; cfg_falling = 0; cfg_en = 1; step(4);
    samples(3);
    cur_req = "R6"; pulse_line(1, 1, 1); step(1); step(1);
    checks++; if (run_flag !== 1) begin
      errors++; $display("FAIL R6 run at third edge actual %0d expected 1", run_flag);
    end
    samples(4); pulse_line(1, 0, 3); drain();

    cur_req = "R5"; cfg_mode = 2; cfg_src = 2; cfg_falling = 1; trig_ext = 1; step(4);
    cfg_en = 1; step(2); pulse_line(1, 0, 4); samples(2); trig_ext = 0; drain();
    cfg_src = 0; cfg_falling = 0; cfg_en = 1; step(2);
    pulse_line(0, 1, 5); samples(2); pulse_line(0, 0, 4); samples(2); drain();
    cfg_src = 1; cfg_en = 1; step(2); pulse_line(1, 1, 4); pulse_line(0, 1, 4);
    samples(2); pulse_line(1, 0, 4); pulse_line(0, 0, 4); drain();
    cfg_src = 3; cfg_en = 1; step(2); pulse_line(1, 1, 4); samples(2);
    pulse_line(1, 0, 4); drain();

    cur_req = "R8"; cfg_mode = 3; cfg_src = 2; cfg_falling = 0; cfg_discard = 2; cfg_en = 1; step(2);
    pulse_line(1, 1, 4); samples(5); pulse_line(1, 0, 2); pulse_line(1, 1, 4); samples(4);
    trig_ext = 0; drain();
    cfg_mode = 1; cfg_discard = 1; cfg_en = 1; step(); samples(5); step(3);
    cfg_en = 0; step(); cfg_en = 1; step(); samples(3); drain();

    cur_req = "R9"; cfg_mode = 3; cfg_discard = 4; cfg_en = 1; step(2);
    pulse_line(1, 1, 4); pulse_line(1, 0, 4); pulse_line(1, 1, 4); samples(2);
    pulse_line(1, 0, 4); pulse_line(1, 1, 4); samples(4); trig_ext = 0; drain();

    cur_req = "R10"; cfg_mode = 4; cfg_src = 2; cfg_discard = 1; cfg_en = 1; step();
    samples(3);
    trig_ext = 1; samples(4); trig_ext = 0; samples(4); trig_ext = 1; samples(3);
    trig_ext = 0; drain();

    cur_req = "R3"; cfg_mode = 0; cfg_discard = 0; cfg_en = 1; step(); samples(2);
    cfg_en = 0; samples(2); step(2); drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule